// File: doc/BRIEF.md
# HS Feedback Subframe Multiplexer

This block arranges the uplink high-speed feedback channel into 2 ms subframes. A subframe is three slots of 2560 chips, and five subframes make one 10 ms radio frame. Every slot of every subframe is sent. The first slot of a subframe carries the hybrid-ARQ acknowledgement. The second and third slots carry the channel-quality report, together with the precoding indication when MIMO is configured. The block does not encode either field. It only places the words that are already encoded.

A timing unit upstream sends two strobes. The frame-start strobe marks the first slot of a radio frame. The slot strobe marks each later slot boundary. A one-bit format select chooses 10 bits per slot (30 per subframe) or 20 bits per slot (60 per subframe). At each accepted strobe the block registers three outputs: the bit word of the new slot, a tag naming the role of that slot, and a valid flag. These outputs hold until the next accepted strobe. An acknowledgement slot with no acknowledgement to send is output as discontinuous transmission: all zeros, with valid low. The block also reports which subframe of the frame is current.

Top module: `hsfb_subframe_mux`

## Requirements
- R1: While reset is asserted and after it is released, `slot_bits` is zero, `slot_tag` is 0, `slot_valid` is 0 and `sf_idx` is 0.
- R2: Before the first `frame_start`, a `slot_stb` has no effect: the outputs keep their reset values.
- R3: A `frame_start` starts slot 0 of subframe 0, whatever the current position is. It wins over a `slot_stb` in the same cycle.
- R4: The tag encodes the slot role: 0 is the acknowledgement, 1 is the upper channel-quality half, 2 is the lower channel-quality half. Each `slot_stb` after synchronisation steps the tag 0→1→2→0. `sf_idx` counts up by one when the tag wraps to 0 and runs 0..4 before it wraps.
- R5: In an acknowledgement slot with `ack_present`=1, `slot_bits` holds the low slot-width bits of `ack_word` and `slot_valid` is 1.
- R6: In an acknowledgement slot with `ack_present`=0, `slot_bits` is all zeros and `slot_valid` is 0.
- R7: The channel-quality word is twice the slot width. Tag-1 slots carry its upper half and tag-2 slots carry its lower half. For format 0 these are bits [19:10] and [9:0]. For format 1 they are bits [39:20] and [19:0]. `slot_valid` is 1 in both slots.
- R8: `fmt_sel`=0 gives a 10-bit slot, with `slot_bits[19:10]` zero. `fmt_sel`=1 gives a 20-bit slot.
- R9: The format is sampled at the strobe that starts slot 0 and applies to the whole subframe. The channel-quality word is sampled at the strobe that starts slot 1, and slot 2 uses that sample.
- R10: The outputs change only on the clock edge where an accepted strobe is sampled. They hold their values in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Marks the first slot of a radio frame |
| slot_stb | input | 1 | Marks a slot boundary |
| fmt_sel | input | 1 | 0: 10 bits per slot, 1: 20 bits per slot |
| ack_present | input | 1 | An acknowledgement is to be sent in this subframe |
| ack_word | input | 20 | Encoded acknowledgement, aligned to bit 0 |
| cqi_word | input | 40 | Encoded channel-quality/precoding word, aligned to bit 0 |
| slot_bits | output | 20 | Bits of the current slot, aligned to bit 0 |
| slot_tag | output | 2 | Role of the current slot |
| slot_valid | output | 1 | The slot carries data (low for discontinuous transmission) |
| sf_idx | output | 3 | Subframe index within the radio frame |

## Verification
The assertions check the following on every cycle:
- the tag order;
- the legal range of the tag and the subframe index;
- that the outputs hold between strobes;
- that no slot is valid before synchronisation;
- that a slot with valid low carries zero bits;
- that channel-quality slots are always valid;
- that the narrow format leaves the upper bits clear.

Only the bench scenarios can show that the right half of the right word lands in each slot. This means tracking the latched format and the latched channel-quality sample across a subframe while the inputs keep changing. The bench also covers the subframe wrap across frames, and a frame-start that arrives in the middle of a subframe.

// File: rtl/hsfb_pkg.sv
package hsfb_pkg;

  localparam int SLOTS_PER_SF = 3;
  localparam int SLOT_IDX_W   = 2;

  typedef enum logic [1:0] {
    TAG_ACK    = 2'd0,
    TAG_CQI_HI = 2'd1,
    TAG_CQI_LO = 2'd2
  } slot_tag_e;

  typedef logic [SLOT_IDX_W-1:0] slot_idx_t;

endpackage

// File: rtl/hsfb_slot_seq.sv
module hsfb_slot_seq
  import hsfb_pkg::*;
#(
  parameter int SF_PER_FRAME = 5,
  localparam int SFW = (SF_PER_FRAME > 1) ? $clog2(SF_PER_FRAME) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_start,
  input  logic           slot_stb,
  output logic           slot_start,
  output slot_idx_t      slot_idx_n,
  output logic [SFW-1:0] sf_idx_q
);

  localparam slot_idx_t       LAST_SLOT = slot_idx_t'(SLOTS_PER_SF - 1);
  localparam logic [SFW-1:0]  LAST_SF   = SFW'(SF_PER_FRAME - 1);

  logic           synced_q, synced_d;
  slot_idx_t      slot_q, slot_d;
  logic [SFW-1:0] sf_d;

  always_comb begin
    synced_d   = synced_q;
    slot_d     = slot_q;
    sf_d       = sf_idx_q;
    slot_start = 1'b0;
    if (frame_start) begin
      synced_d   = 1'b1;
      slot_d     = '0;
      sf_d       = '0;
      slot_start = 1'b1;
    end else if (slot_stb && synced_q) begin
      slot_start = 1'b1;
      if (slot_q == LAST_SLOT) begin
        slot_d = '0;
        sf_d   = (sf_idx_q == LAST_SF) ? '0 : sf_idx_q + SFW'(1);
      end else begin
        slot_d = slot_q + slot_idx_t'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      synced_q <= 1'b0;
      slot_q   <= '0;
      sf_idx_q <= '0;
    end else begin
      synced_q <= synced_d;
      slot_q   <= slot_d;
      sf_idx_q <= sf_d;
    end
  end

  assign slot_idx_n = slot_d;

endmodule

// File: rtl/hsfb_field_sel.sv
module hsfb_field_sel
  import hsfb_pkg::*;
#(
  parameter int W_NARROW = 10,
  parameter int W_WIDE   = 20
) (
  input  slot_idx_t           slot_idx,
  input  logic                wide,
  input  logic                ack_present,
  input  logic [W_WIDE-1:0]   ack_word,
  input  logic [2*W_WIDE-1:0] cqi_word,
  output logic [W_WIDE-1:0]   bits,
  output slot_tag_e           tag,
  output logic                valid
);

  localparam int PAD = W_WIDE - W_NARROW;

  logic [W_WIDE-1:0] ack_f, hi_f, lo_f;

  generate
    if (PAD > 0) begin : g_pad
      always_comb begin
        ack_f = wide ? ack_word : {{PAD{1'b0}}, ack_word[W_NARROW-1:0]};
        hi_f  = wide ? cqi_word[2*W_WIDE-1:W_WIDE]
                     : {{PAD{1'b0}}, cqi_word[2*W_NARROW-1:W_NARROW]};
        lo_f  = wide ? cqi_word[W_WIDE-1:0]
                     : {{PAD{1'b0}}, cqi_word[W_NARROW-1:0]};
      end
    end else begin : g_same
      always_comb begin
        ack_f = ack_word;
        hi_f  = cqi_word[2*W_WIDE-1:W_WIDE];
        lo_f  = cqi_word[W_WIDE-1:0];
      end
    end
  endgenerate

  always_comb begin
    unique case (slot_idx)
      2'd1: begin
        tag   = TAG_CQI_HI;
        bits  = hi_f;
        valid = 1'b1;
      end
      2'd2: begin
        tag   = TAG_CQI_LO;
        bits  = lo_f;
        valid = 1'b1;
      end
      default: begin
        tag   = TAG_ACK;
        bits  = ack_present ? ack_f : '0;
        valid = ack_present;
      end
    endcase
  end

endmodule

// File: rtl/hsfb_subframe_mux.sv
module hsfb_subframe_mux
  import hsfb_pkg::*;
#(
  parameter int W_NARROW     = 10,
  parameter int W_WIDE       = 20,
  parameter int SF_PER_FRAME = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        frame_start,
  input  logic                        slot_stb,
  input  logic                        fmt_sel,
  input  logic                        ack_present,
  input  logic [W_WIDE-1:0]           ack_word,
  input  logic [2*W_WIDE-1:0]         cqi_word,
  output logic [W_WIDE-1:0]           slot_bits,
  output logic [1:0]                  slot_tag,
  output logic                        slot_valid,
  output logic [$clog2(SF_PER_FRAME)-1:0] sf_idx
);

  localparam int SFW = $clog2(SF_PER_FRAME);

  logic                slot_start;
  slot_idx_t           slot_idx_n;
  logic                fmt_q, fmt_eff;
  logic [2*W_WIDE-1:0] cqi_q, cqi_eff;
  logic [W_WIDE-1:0]   bits_n;
  slot_tag_e           tag_n;
  logic                valid_n;

  hsfb_slot_seq #(.SF_PER_FRAME(SF_PER_FRAME)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .slot_stb   (slot_stb),
    .slot_start (slot_start),
    .slot_idx_n (slot_idx_n),
    .sf_idx_q   (sf_idx)
  );

  // The format is taken live in slot 0 and then held for the subframe.
  // The CQI word is taken live in slot 1 and then held for slot 2.
  always_comb begin
    fmt_eff = (slot_idx_n == 2'd0) ? fmt_sel  : fmt_q;
    cqi_eff = (slot_idx_n == 2'd1) ? cqi_word : cqi_q;
  end

  hsfb_field_sel #(.W_NARROW(W_NARROW), .W_WIDE(W_WIDE)) u_sel (
    .slot_idx   (slot_idx_n),
    .wide       (fmt_eff),
    .ack_present(ack_present),
    .ack_word   (ack_word),
    .cqi_word   (cqi_eff),
    .bits       (bits_n),
    .tag        (tag_n),
    .valid      (valid_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q      <= 1'b0;
      cqi_q      <= '0;
      slot_bits  <= '0;
      slot_tag   <= TAG_ACK;
      slot_valid <= 1'b0;
    end else if (slot_start) begin
      fmt_q      <= fmt_eff;
      cqi_q      <= cqi_eff;
      slot_bits  <= bits_n;
      slot_tag   <= tag_n;
      slot_valid <= valid_n;
    end
  end

endmodule

// File: rtl/hsfb_chk.sv
module hsfb_chk #(
  parameter int W_NARROW     = 10,
  parameter int W_WIDE       = 20,
  parameter int SF_PER_FRAME = 5
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            frame_start,
  input logic                            slot_stb,
  input logic                            fmt_sel,
  input logic [W_WIDE-1:0]               slot_bits,
  input logic [1:0]                      slot_tag,
  input logic                            slot_valid,
  input logic [$clog2(SF_PER_FRAME)-1:0] sf_idx
);

  logic       synced_c;
  logic [1:0] tag_follow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) synced_c <= 1'b0;
    else if (frame_start) synced_c <= 1'b1;
  end

  always_comb tag_follow = (slot_tag == 2'd2) ? 2'd0 : slot_tag + 2'd1;

  assert_tag_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_tag != 2'd3);

  assert_sf_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sf_idx) < SF_PER_FRAME);

  assert_frame_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (slot_tag == 2'd0) && (sf_idx == '0));

  assert_slot_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_stb && !frame_start && synced_c) |=> slot_tag == $past(tag_follow));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !slot_stb) |=>
      ($stable(slot_bits) && $stable(slot_tag) && $stable(slot_valid) && $stable(sf_idx)));

  assert_dtx_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tag == 2'd0 && !slot_valid) |-> slot_bits == '0);

  assert_cqi_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tag != 2'd0) |-> slot_valid);

  assert_unsynced_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !synced_c |-> !slot_valid);

  assert_narrow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !fmt_sel) |=> slot_bits[W_WIDE-1:W_NARROW] == '0);

endmodule

bind hsfb_subframe_mux hsfb_chk #(
  .W_NARROW(W_NARROW), .W_WIDE(W_WIDE), .SF_PER_FRAME(SF_PER_FRAME)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .slot_stb(slot_stb),
  .fmt_sel(fmt_sel), .slot_bits(slot_bits), .slot_tag(slot_tag),
  .slot_valid(slot_valid), .sf_idx(sf_idx)
);

// File: tb/tb_hsfb_subframe_mux.sv
module tb_hsfb_subframe_mux;

  localparam int CLK_PERIOD = 10;
  localparam int WN = 10;
  localparam int WW = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          frame_start, slot_stb, fmt_sel, ack_present;
  logic [WW-1:0] ack_word;
  logic [2*WW-1:0] cqi_word;
  logic [WW-1:0] slot_bits;
  logic [1:0]    slot_tag;
  logic          slot_valid;
  logic [2:0]    sf_idx;

  int total = 0;
  int bad   = 0;

  // bench model state
  logic          m_sync;
  int            m_slot, m_sf;
  logic          m_fmt;
  logic [2*WW-1:0] m_cqi;
  logic [WW-1:0] e_bits;
  logic [1:0]    e_tag;
  logic          e_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsfb_subframe_mux dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .slot_stb(slot_stb),
    .fmt_sel(fmt_sel), .ack_present(ack_present), .ack_word(ack_word),
    .cqi_word(cqi_word), .slot_bits(slot_bits), .slot_tag(slot_tag),
    .slot_valid(slot_valid), .sf_idx(sf_idx)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    chk({req, " bits"},  64'(slot_bits),  64'(e_bits));
    chk({req, " tag"},   64'(slot_tag),   64'(e_tag));
    chk({req, " valid"}, 64'(slot_valid), 64'(e_valid));
    chk({req, " sf"},    64'(sf_idx),     64'(m_sf));
  endtask

  // Computes the expected outputs from the requirements for the slot that was just started.
  task automatic model_update(input logic fs, input logic ss);
    logic started;
    int   w;
    logic [2*WW-1:0] mask;
    started = 1'b0;
    if (fs) begin
      m_sync = 1'b1; m_slot = 0; m_sf = 0; started = 1'b1;
    end else if (ss && m_sync) begin
      started = 1'b1;
      if (m_slot == 2) begin
        m_slot = 0; m_sf = (m_sf == 4) ? 0 : m_sf + 1;
      end else m_slot = m_slot + 1;
    end
    if (started) begin
      if (m_slot == 0) m_fmt = fmt_sel;
      if (m_slot == 1) m_cqi = cqi_word;
      w    = m_fmt ? WW : WN;
      mask = (40'd1 << w) - 40'd1;
      e_tag = 2'(m_slot);
      if (m_slot == 0) begin
        e_bits  = ack_present ? WW'(40'(ack_word) & mask) : '0;
        e_valid = ack_present;
      end else if (m_slot == 1) begin
        e_bits  = WW'((m_cqi >> w) & mask);
        e_valid = 1'b1;
      end else begin
        e_bits  = WW'(m_cqi & mask);
        e_valid = 1'b1;
      end
    end
  endtask

  task automatic strobe(input logic fs, input logic ss, input logic f,
                        input logic ap, input logic [WW-1:0] aw,
                        input logic [2*WW-1:0] cw, input string req);
    @(negedge clk);
    frame_start = fs; slot_stb = ss; fmt_sel = f;
    ack_present = ap; ack_word = aw; cqi_word = cw;
    @(posedge clk);
    model_update(fs, ss);
    @(negedge clk);
    frame_start = 1'b0; slot_stb = 1'b0;
    ack_word = ~ack_word; cqi_word = ~cqi_word; fmt_sel = ~fmt_sel;
    compare_all(req);
  endtask

  task automatic idle_hold(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare_all("R10 hold");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    frame_start = 1'b0; slot_stb = 1'b0; fmt_sel = 1'b0; ack_present = 1'b0;
    ack_word = '0; cqi_word = '0;
    m_sync = 1'b0; m_slot = 0; m_sf = 0; m_fmt = 1'b0; m_cqi = '0;
    e_bits = '0; e_tag = 2'd0; e_valid = 1'b0;
    repeat (3) @(negedge clk);
    compare_all("R1 in reset");
    rst_n = 1'b1;
    idle_hold(1);
    compare_all("R1 after reset");

    // R2: strobes before any frame start are ignored
    for (int i = 0; i < 4; i++)
      strobe(1'b0, 1'b1, 1'b1, 1'b1, 20'hFFFFF, {40{1'b1}}, "R2 unsynced");

    // Sweep over the format and acknowledgement patterns (R4..R9)
    for (int cfg = 0; cfg < 4; cfg++) begin
      strobe(1'b1, 1'b0, cfg[0], cfg[1], WW'(cfg * 977 + 3), 40'hC3A5_5A3C_96, "R3 frame start");
      for (int i = 1; i < 33; i++) begin
        logic [WW-1:0]   aw;
        logic [2*WW-1:0] cw;
        aw = WW'(i * 7919 + cfg * 131);
        cw = {WW'(i * 40503 + cfg), WW'(i * 65599 ^ 20'h5A5A5)};
        strobe(1'b0, 1'b1, cfg[0] ^ i[0], ((i / 3) % 2 == 1) ^ cfg[1], aw, cw,
               (i % 3 == 0) ? "R5 R6 ack slot" : "R7 R8 R9 cqi slot");
        idle_hold(i % 3);
      end
    end

    // R3: frame start in the middle of a subframe, with slot strobe also high
    strobe(1'b1, 1'b0, 1'b1, 1'b1, 20'h12345, 40'h11111_22222, "R3 sync");
    strobe(1'b0, 1'b1, 1'b0, 1'b1, 20'h0, 40'hABCDE_F0123, "R4 slot1");
    strobe(1'b1, 1'b1, 1'b0, 1'b1, 20'hFEDCB, 40'h0, "R3 priority");
    chk("R3 tag after priority", 64'(slot_tag), 64'd0);
    chk("R8 narrow upper zero", 64'(slot_bits[WW-1:WN]), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule